// File: doc/BRIEF.md
# Asynchronous SRAM Write/Read Timing Monitor

This block watches the pins of an asynchronous single-bit-wide static RAM (address bus, active-low chip select, active-low write enable and serial data in) with a fast sampling clock. All pins pass through multi-stage synchronizers. The monitor then measures, in whole sampling ticks, the distance between edges on the synchronized samples. It raises a sticky flag for each minimum-timing rule of a write or read cycle that is broken. Ports are not checked for data correctness. Nothing finer than one tick is resolved.

A write is the overlap of chip select low and write enable low. It starts when the later of the two falls and ends at the first rise of either. Every limit is a parameter in ticks. The defaults assume a 5 ns tick. A combined error bit and a saturating violation counter summarize the flags for a status path elsewhere in the chip.

Top module: `sram_timing_monitor`

## Requirements
- R1: After reset every flag, the combined error bit and the counter read zero.
- R2: Flag bit 0 sets when the address changes while write enable is low in both this and the previous sample.
- R3: Flag bit 1 sets when a write ends fewer than T_WP (default 10) ticks after it started; a write ends at the first rise of chip select or write enable, whichever is earlier.
- R4: Flag bit 2 sets when data in changed fewer than T_DS (default 7) ticks before a write end; flag bit 3 sets when data in changes fewer than T_DH (default 1) ticks after a write end.
- R5: Flag bit 4 sets when the address changed fewer than T_AS (default 2) ticks before a write start; flag bit 5 sets when it changed fewer than T_AW (default 16) ticks before a write end.
- R6: Flag bit 6 sets when the address changes fewer than T_AH (default 1) ticks after a write end.
- R7: Flag bit 7 sets when chip select fell fewer than T_CSW (default 2) ticks before a write start, which includes chip select falling with or after write enable; flag bit 8 sets when chip select fell fewer than T_CSE (default 17) ticks before a write end.
- R8: Flag bit 9 sets when, with chip select low and write enable high, two address changes are fewer than T_RC (default 27) ticks apart.
- R9: Flag bit 10 sets when two write starts are fewer than T_WC (default 27) ticks apart.
- R10: Flags stay set until reset, and the combined error bit is high exactly when any flag is set.
- R11: The counter adds the number of rules that fire in each tick and saturates at 2^CNT_W-1 (CNT_W defaults to 16).
- R12: An interval exactly equal to its limit is legal. A flag appears no later than SYNC_STAGES+1 ticks after the pin edge that completes the violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one period is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_addr | input | AW (12) | RAM address pins |
| ram_cs_n | input | 1 | RAM chip select, active low |
| ram_we_n | input | 1 | RAM write enable, active low |
| ram_din | input | 1 | RAM data in pin |
| viol | output | NRULE (11) | Sticky per-rule violation flags, bit order as in the requirements |
| viol_any | output | 1 | High once any rule has fired since reset |
| viol_count | output | CNT_W (16) | Saturating count of rule firings |

## Verification
Randomly shaped write cycles vary the address lead, chip select lead, overlap width, data setup and address hold around their limits. Some of these cycles also move the address inside the write or end the write by chip select first. This separates each write-end rule from the others and shows whether both kinds of write end are recognized. Directed runs place a write exactly on every limit and then one tick short of it, so an off-by-one comparison shows up. Paired address changes in a read, and back-to-back writes, are spaced 27 and then 26 ticks apart. Running several cycles between resets, with a narrow counter, exposes lost stickiness and a missing counter saturation.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
   localparam int NRULE = 11;
   localparam int NEVT  = 5;

   // rule bit positions (visible in the viol port)
   localparam int RB_ADDR_MOVE = 0;
   localparam int RB_PULSE     = 1;
   localparam int RB_DSETUP    = 2;
   localparam int RB_DHOLD     = 3;
   localparam int RB_AS_START  = 4;
   localparam int RB_AS_END    = 5;
   localparam int RB_AHOLD     = 6;
   localparam int RB_CS_ORDER  = 7;
   localparam int RB_CS_END    = 8;
   localparam int RB_RCYCLE    = 9;
   localparam int RB_WCYCLE    = 10;

   // edge-age counter slots
   localparam int EV_ADDR   = 0;
   localparam int EV_DIN    = 1;
   localparam int EV_CSFALL = 2;
   localparam int EV_WSTART = 3;
   localparam int EV_WEND   = 4;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned popcnt(input logic [NRULE-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < NRULE; i++) n += {31'd0, v[i]};
      return n;
   endfunction
endpackage

// File: rtl/sram_mon_sync.sv
module sram_mon_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= RST_VAL;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/sram_mon_age.sv
module sram_mon_age #(
   parameter int SAT = 27,
   parameter int W   = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   output logic [W-1:0] age,
   output logic [W-1:0] gap
);
   localparam logic [W-1:0] SAT_V = W'(SAT);
   logic [W-1:0] cnt_q;

   // gap: ticks since the previous event, ignoring one in this tick
   assign gap = (cnt_q >= SAT_V) ? SAT_V : cnt_q + W'(1);
   assign age = evt ? '0 : gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= SAT_V;
      else        cnt_q <= age;
   end
endmodule

// File: rtl/sram_mon_rules.sv
module sram_mon_rules
   import sram_mon_pkg::*;
#(
   parameter int AW    = 12,
   parameter int T_WP  = 10,
   parameter int T_DS  = 7,
   parameter int T_DH  = 1,
   parameter int T_AS  = 2,
   parameter int T_AW  = 16,
   parameter int T_AH  = 1,
   parameter int T_CSW = 2,
   parameter int T_CSE = 17,
   parameter int T_RC  = 27,
   parameter int T_WC  = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_s,
   input  logic             cs_s,
   input  logic             we_s,
   input  logic             din_s,
   output logic [NRULE-1:0] fire
);
   localparam int SAT = imax(imax(imax(T_WP, T_DS), imax(T_DH, T_AS)),
                             imax(imax(T_AW, T_AH), imax(imax(T_CSW, T_CSE),
                                                         imax(T_RC, T_WC))));
   localparam int CW  = $clog2(SAT + 2);

   localparam logic [CW-1:0] L_WP  = CW'(T_WP);
   localparam logic [CW-1:0] L_DS  = CW'(T_DS);
   localparam logic [CW-1:0] L_DH  = CW'(T_DH);
   localparam logic [CW-1:0] L_AS  = CW'(T_AS);
   localparam logic [CW-1:0] L_AW  = CW'(T_AW);
   localparam logic [CW-1:0] L_AH  = CW'(T_AH);
   localparam logic [CW-1:0] L_CSW = CW'(T_CSW);
   localparam logic [CW-1:0] L_CSE = CW'(T_CSE);
   localparam logic [CW-1:0] L_RC  = CW'(T_RC);
   localparam logic [CW-1:0] L_WC  = CW'(T_WC);

   logic [AW-1:0] addr_q;
   logic          cs_q, we_q, din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cs_q   <= 1'b1;
         we_q   <= 1'b1;
         din_q  <= 1'b0;
      end else begin
         addr_q <= addr_s;
         cs_q   <= cs_s;
         we_q   <= we_s;
         din_q  <= din_s;
      end
   end

   logic addr_chg, din_chg, cs_fall, wr_now, wr_was, wr_start, wr_end;
   assign addr_chg = (addr_s != addr_q);
   assign din_chg  = (din_s != din_q);
   assign cs_fall  = cs_q & ~cs_s;
   assign wr_now   = ~cs_s & ~we_s;
   assign wr_was   = ~cs_q & ~we_q;
   assign wr_start = wr_now & ~wr_was;
   assign wr_end   = wr_was & ~wr_now;

   logic [NEVT-1:0]         evt;
   logic [NEVT-1:0][CW-1:0] age;
   logic [NEVT-1:0][CW-1:0] gap;

   assign evt[EV_ADDR]   = addr_chg;
   assign evt[EV_DIN]    = din_chg;
   assign evt[EV_CSFALL] = cs_fall;
   assign evt[EV_WSTART] = wr_start;
   assign evt[EV_WEND]   = wr_end;

   for (genvar k = 0; k < NEVT; k++) begin : g_age
      sram_mon_age #(.SAT(SAT), .W(CW)) u_age (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt[k]),
         .age   (age[k]),
         .gap   (gap[k])
      );
   end

   always_comb begin
      fire = '0;
      fire[RB_ADDR_MOVE] = addr_chg & ~we_s & ~we_q;
      fire[RB_PULSE]     = wr_end   & (age[EV_WSTART] < L_WP);
      fire[RB_DSETUP]    = wr_end   & (age[EV_DIN]    < L_DS);
      fire[RB_DHOLD]     = din_chg  & (age[EV_WEND]   < L_DH);
      fire[RB_AS_START]  = wr_start & (age[EV_ADDR]   < L_AS);
      fire[RB_AS_END]    = wr_end   & (age[EV_ADDR]   < L_AW);
      fire[RB_AHOLD]     = addr_chg & (age[EV_WEND]   < L_AH);
      fire[RB_CS_ORDER]  = wr_start & (age[EV_CSFALL] < L_CSW);
      fire[RB_CS_END]    = wr_end   & (age[EV_CSFALL] < L_CSE);
      fire[RB_RCYCLE]    = addr_chg & ~cs_s & we_s & we_q & (gap[EV_ADDR] < L_RC);
      fire[RB_WCYCLE]    = wr_start & (gap[EV_WSTART] < L_WC);
   end
endmodule

// File: rtl/sram_mon_tally.sv
module sram_mon_tally
   import sram_mon_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NRULE-1:0] fire,
   output logic [NRULE-1:0] flags,
   output logic             any,
   output logic [CNT_W-1:0] count
);
   for (genvar b = 0; b < NRULE; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[b] <= 1'b0;
         else if (fire[b]) flags[b] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     any <= 1'b0;
      else if (|fire) any <= 1'b1;
   end

   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] count_d;

   always_comb begin
      sum     = {1'b0, count} + (CNT_W+1)'(popcnt(fire));
      count_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count_d;
   end
endmodule

// File: rtl/sram_timing_monitor.sv
module sram_timing_monitor
   import sram_mon_pkg::*;
#(
   parameter int AW          = 12,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int T_WP        = 10,
   parameter int T_DS        = 7,
   parameter int T_DH        = 1,
   parameter int T_AS        = 2,
   parameter int T_AW        = 16,
   parameter int T_AH        = 1,
   parameter int T_CSW       = 2,
   parameter int T_CSE       = 17,
   parameter int T_RC        = 27,
   parameter int T_WC        = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    ram_addr,
   input  logic             ram_cs_n,
   input  logic             ram_we_n,
   input  logic             ram_din,
   output logic [NRULE-1:0] viol,
   output logic             viol_any,
   output logic [CNT_W-1:0] viol_count
);
   localparam int              SW   = AW + 3;
   localparam logic [SW-1:0]   SRST = {{AW{1'b0}}, 3'b110};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < $clog2(NRULE + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for one tick of firings");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be positive");
   end
   if (T_WP < 1 || T_DS < 1 || T_DH < 1 || T_AS < 1 || T_AW < 1 || T_AH < 1 ||
       T_CSW < 1 || T_CSE < 1 || T_RC < 1 || T_WC < 1) begin : g_bad_lim
      $error("every tick limit must be at least 1");
   end

   logic [SW-1:0] pins_s;
   logic [AW-1:0] addr_s;
   logic          cs_s, we_s, din_s;

   sram_mon_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SRST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ram_addr, ram_cs_n, ram_we_n, ram_din}),
      .q     (pins_s)
   );

   assign {addr_s, cs_s, we_s, din_s} = pins_s;

   logic [NRULE-1:0] fire;

   sram_mon_rules #(
      .AW(AW), .T_WP(T_WP), .T_DS(T_DS), .T_DH(T_DH), .T_AS(T_AS),
      .T_AW(T_AW), .T_AH(T_AH), .T_CSW(T_CSW), .T_CSE(T_CSE),
      .T_RC(T_RC), .T_WC(T_WC)
   ) u_rules (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_s (addr_s),
      .cs_s   (cs_s),
      .we_s   (we_s),
      .din_s  (din_s),
      .fire   (fire)
   );

   sram_mon_tally #(.CNT_W(CNT_W)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .flags (viol),
      .any   (viol_any),
      .count (viol_count)
   );
endmodule

// File: rtl/sram_mon_chk.sv
module sram_mon_chk
   import sram_mon_pkg::*;
#(
   parameter int AW    = 12,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    addr_s,
   input logic             we_s,
   input logic [NRULE-1:0] viol,
   input logic             viol_any,
   input logic [CNT_W-1:0] viol_count
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R2: an address move under a held-low write enable is flagged next tick
   a_r2_addr_move: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr_s != $past(addr_s)) && !we_s && !$past(we_s)) |=> viol[RB_ADDR_MOVE]);

   // R10: no flag ever clears without reset
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((viol & $past(viol)) == $past(viol)));

   // R10: combined bit tracks the flag vector
   a_r10_any: assert property (@(posedge clk) disable iff (!rst_n)
      viol_any == (|viol));

   // R11: counter never decreases
   a_r11_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (viol_count >= $past(viol_count)));

   // R11: counter stays at its ceiling
   a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_count == CMAX) |=> (viol_count == CMAX));

   // R11: a set flag implies a nonzero count
   a_r11_count_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (|viol) |-> (viol_count != '0));
endmodule

bind sram_timing_monitor sram_mon_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_s     (addr_s),
   .we_s       (we_s),
   .viol       (viol),
   .viol_any   (viol_any),
   .viol_count (viol_count)
);

// File: tb/sim_sram_timing_monitor.sv
`timescale 1ns/1ps
module sim_sram_timing_monitor;
   localparam int AW    = 12;
   localparam int NR    = 11;
   localparam int CNT_W = 4;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic            cs_n = 1'b1;
   logic            we_n = 1'b1;
   logic            din = 1'b0;
   logic [NR-1:0]   viol;
   logic            viol_any;
   logic [CNT_W-1:0] viol_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [NR-1:0] exp_flags;
   int            exp_cnt;

   always #10 clk = ~clk;

   sram_timing_monitor #(.AW(AW), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ram_addr(addr), .ram_cs_n(cs_n),
      .ram_we_n(we_n), .ram_din(din), .viol(viol), .viol_any(viol_any),
      .viol_count(viol_count)
   );

   function automatic string bit_tag(input int b);
      case (b)
         0:       return "R2";
         1:       return "R3";
         2, 3:    return "R4";
         4, 5:    return "R5";
         6:       return "R6";
         7, 8:    return "R7";
         9:       return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic int popc(input logic [NR-1:0] v);
      int n = 0;
      for (int i = 0; i < NR; i++) n += int'(v[i]);
      return n;
   endfunction

   // expected flags for one write shaped by tick offsets; write start at W=20
   function automatic logic [NR-1:0] exp_mask(input int as, input int cl, input int pw,
                                              input int ds, input int ah, input bit mv);
      logic [NR-1:0] m = '0;
      int w = 20;
      int e = w + pw;
      int alast = mv ? w + 1 : w - as;
      m[0]  = mv;
      m[1]  = pw < 10;
      m[2]  = ds < 7;
      m[3]  = ds == 0;
      m[4]  = as < 2;
      m[5]  = ((e - alast) < 16) || (ah == 0);
      m[6]  = ah < 1;
      m[7]  = cl < 2;
      m[8]  = (pw + cl) < 17;
      return m;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cs_n = 1'b1; we_n = 1'b1;
      tick(3);
      rst_n = 1'b1;
      exp_flags = '0;
      exp_cnt = 0;
      tick(3);
   endtask

   task automatic add_exp(input logic [NR-1:0] m);
      exp_flags |= m;
      exp_cnt += popc(m);
      if (exp_cnt > CMAX) exp_cnt = CMAX;
   endtask

   task automatic check_all();
      tick(5);   // R12: pins settle through the synchronizer and flag register
      for (int b = 0; b < NR; b++)
         chk(viol[b] == exp_flags[b], bit_tag(b), int'(viol[b]), int'(exp_flags[b]));
      chk(viol_any == (|exp_flags), "R10", int'(viol_any), int'(|exp_flags));
      chk(int'(viol_count) == exp_cnt, "R11", int'(viol_count), exp_cnt);
   endtask

   // one write cycle; ce ends it by chip select first, write enable 2 ticks later
   task automatic write_scen(input int as, input int cl, input int pw, input int ds,
                             input int ah, input bit mv, input bit ce);
      int w = 20;
      int e = w + pw;
      int ahx = ce ? 3 : ah;
      int we_up = ce ? e + 2 : e;
      tick(40);
      for (int t = 0; t <= e + 6; t++) begin
         if (t == w - as) addr = addr + 1'b1;
         if (mv && t == w + 1) addr = addr + 1'b1;
         if (t == e + ahx) addr = addr + 1'b1;
         if (t == w - cl) cs_n = 1'b0;
         if (t == w) we_n = 1'b0;
         if (t == e) cs_n = 1'b1;
         if (t == we_up) we_n = 1'b1;
         if (t == e - ds) din = ~din;
         tick(1);
      end
      add_exp(exp_mask(as, cl, pw, ds, ahx, mv));
      check_all();
   endtask

   task automatic read_gap(input int g);
      cs_n = 1'b0;
      tick(35);
      addr = addr + 1'b1;
      tick(g);
      addr = addr + 1'b1;
      tick(6);
      cs_n = 1'b1;
      if (g < 27) add_exp(11'b1 << 9);
      check_all();
   endtask

   task automatic write_gap(input int g);
      cs_n = 1'b0;
      tick(20);
      we_n = 1'b0; tick(12);
      we_n = 1'b1; tick(g - 12);
      we_n = 1'b0; tick(12);
      we_n = 1'b1; tick(2);
      cs_n = 1'b1;
      if (g < 27) add_exp(11'b1 << 10);
      check_all();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5104));
      exp_flags = '0;
      exp_cnt = 0;
      tick(3);
      do_reset();
      // R1: reset state
      chk(viol == '0, "R1", int'(viol), 0);
      chk(viol_any == 1'b0, "R1", int'(viol_any), 0);
      chk(viol_count == '0, "R1", int'(viol_count), 0);

      // R12: every limit met exactly -> clean
      do_reset(); write_scen(6, 7, 10, 7, 1, 1'b0, 1'b0);
      // one tick short on pulse, address-to-end, CS-to-end, data setup
      do_reset(); write_scen(6, 7, 9, 6, 1, 1'b0, 1'b0);
      // R7 / R5: CS and address one tick short of write start
      do_reset(); write_scen(1, 1, 14, 8, 1, 1'b0, 1'b0);
      // R7: CS falls together with WE
      do_reset(); write_scen(5, 0, 14, 8, 1, 1'b0, 1'b0);
      // R4: data toggles on the write end tick
      do_reset(); write_scen(5, 5, 14, 0, 1, 1'b0, 1'b0);
      // R2: address moves inside the write
      do_reset(); write_scen(5, 5, 14, 8, 1, 1'b1, 1'b0);
      // R6: address moves on the write end tick
      do_reset(); write_scen(5, 5, 14, 8, 0, 1'b0, 1'b0);
      // R3: write ended by chip select first, too short
      do_reset(); write_scen(5, 5, 8, 8, 3, 1'b0, 1'b1);
      // R8: read address spacing on and one under the limit
      do_reset(); read_gap(27);
      do_reset(); read_gap(26);
      // R9: write start spacing on and one under the limit
      do_reset(); write_gap(27);
      do_reset(); write_gap(26);

      // random writes, 8 per reset so flags accumulate and the count saturates (R10, R11)
      for (int grp = 0; grp < 6; grp++) begin
         do_reset();
         for (int k = 0; k < 8; k++) begin
            write_scen($urandom_range(0, 12), $urandom_range(0, 12),
                       $urandom_range(6, 14), $urandom_range(0, 9),
                       $urandom_range(0, 3), 1'($urandom_range(0, 3) == 0),
                       1'($urandom_range(0, 4) == 0));
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule